// File: doc/BRIEF.md
# SpaceWire Link State Controller

This block is the link-level sequencer of a serial point-to-point link. After reset it waits out an error-recovery period and then a settling period with the receiver enabled. It then starts the link when the application asks for it. It walks through the handshake in which the two ends exchange NULL and flow-control (FCT) characters, and it holds the link in its operational state until an error, a disconnect or an application request ends it. Every exit from the operational state goes through the same recovery sequence, so a failed link tries to reconnect by itself.

The receiver decoder reports single-cycle events: NULL, FCT, data or time-code character, disconnect, parity error and escape error. The transmitter reports each data character it sends. From these events the block drives the receiver enable, three transmit permissions and three status lines. It also raises one-cycle error pulses and keeps the transmit credit count. A credit overflow is detected inside the block from that count.

Top module: `spwLinkController`

## Requirements
- R1: While `rstN` is low and afterwards, the status lines and `rxEnable` are low. The recovery period lasts exactly `RESET_CYC` cycles after reset release, and `rxEnable` rises after the `RESET_CYC`-th clock edge.
- R2: Once `rxEnable` has risen, the settling period lasts `TIMEOUT_CYC` cycles before the idle state is reached. With `linkStart` held high, `isStarted` rises `TIMEOUT_CYC + 1` edges after `rxEnable` rose.
- R3: In the idle state, with `linkStart` and `autoStart` low, the link stays idle indefinitely. With `autoStart` high, it starts on the edge at which a NULL is received, or at which a NULL received earlier since the last recovery is on record.
- R4: `linkDis` high keeps the link idle whatever `linkStart` and `autoStart` say. In the Started, Connecting or Run state, `linkDis` sends the link to recovery on the next edge and raises no error pulse.
- R5: Started moves to Connecting once a NULL has been received (sticky since the last recovery). Connecting moves to Run on an FCT, and that FCT sets the credit to `CREDIT_STEP`.
- R6: If Started or Connecting has not progressed after `TIMEOUT_CYC` cycles, the link falls back to recovery (`rxEnable` low).
- R7: An FCT or data character in Started, or a data character in Connecting, sends the link to recovery on the next edge without any error pulse.
- R8: In Run, a disconnect, parity error or escape error raises `errDisc`, `errPar` or `errEsc` respectively, for exactly one cycle, in the same cycle in which the link is back in recovery.
- R9: In Connecting and Run, each FCT adds `CREDIT_STEP` to `txCredit`. Each `txCharSent` in Run takes one credit, and the count never goes below 0. An FCT that would push the count above `CREDIT_MAX` raises `errCred` for one cycle and sends the link to recovery.
- R10: `sendNullOk` is high in Started, Connecting and Run. `sendFctOk` is high in Connecting and Run only. `sendDataOk` is high in Run only.
- R11: `isStarted`, `isConnecting` and `isRunning` are each high only in their own state. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| autoStart | input | 1 | Start when the far end is heard sending NULLs |
| linkStart | input | 1 | Start unconditionally from idle |
| linkDis | input | 1 | Block start / tear down a live link |
| gotNull | input | 1 | NULL received (one-cycle event) |
| gotFct | input | 1 | FCT received (one-cycle event) |
| gotData | input | 1 | Data character or time-code received |
| rxDisconnect | input | 1 | Receiver lost the incoming signal |
| rxParityErr | input | 1 | Receiver parity error |
| rxEscapeErr | input | 1 | Receiver invalid escape sequence |
| txCharSent | input | 1 | Transmitter sent one data character |
| rxEnable | output | 1 | Receiver enable |
| sendNullOk | output | 1 | Transmitter may send NULLs |
| sendFctOk | output | 1 | Transmitter may send FCTs |
| sendDataOk | output | 1 | Transmitter may send data and time-codes |
| isStarted | output | 1 | Link is in Started |
| isConnecting | output | 1 | Link is in Connecting |
| isRunning | output | 1 | Link is in Run |
| errDisc | output | 1 | Disconnect in Run, one-cycle pulse |
| errPar | output | 1 | Parity error in Run, one-cycle pulse |
| errEsc | output | 1 | Escape error in Run, one-cycle pulse |
| errCred | output | 1 | Credit overflow, one-cycle pulse |
| txCredit | output | $clog2(CREDIT_MAX+1) | Transmit credit count |

## Verification
The state register, credit counter and error pulses each sit one register behind their inputs. A receiver event applied before an edge is therefore visible on every output right after that edge, and an error pulse is gone one edge later. Timer-driven moves follow a fixed count: recovery ends after `RESET_CYC` edges, and settling and handshake timeouts after `TIMEOUT_CYC` edges counted from the edge that entered the state. The bench applies each event for exactly one edge and samples shortly after it. It counts edges to each observable change and compares the count with these figures from the requirements.

// File: rtl/spwLinkPkg.sv
`timescale 1ns/1ps
package spwLinkPkg;
  typedef enum logic [2:0] {
    ST_ERR_RESET  = 3'd0,
    ST_ERR_WAIT   = 3'd1,
    ST_READY      = 3'd2,
    ST_STARTED    = 3'd3,
    ST_CONNECTING = 3'd4,
    ST_RUN        = 3'd5
  } linkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClear;
    logic nullClear;
    logic creditClear;
    logic creditAdd;
    logic creditTake;
  } dpCtrl_t;

  // flags from datapath to control
  typedef struct packed {
    logic resetDone;
    logic timeoutHit;
    logic nullSeen;
    logic creditWouldOverflow;
    logic creditAvail;
  } dpStat_t;
endpackage

// File: rtl/spwLinkDatapath.sv
`timescale 1ns/1ps
module spwLinkDatapath
  import spwLinkPkg::*;
#(
  parameter int RESET_CYC   = 640,
  parameter int TIMEOUT_CYC = 1280,
  parameter int CREDIT_STEP = 8,
  parameter int CREDIT_MAX  = 56,
  localparam int CRED_W     = $clog2(CREDIT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              gotNull,
  output dpStat_t           stat,
  output logic [CRED_W-1:0] txCredit
);
  localparam int TMAX    = (RESET_CYC > TIMEOUT_CYC) ? RESET_CYC : TIMEOUT_CYC;
  localparam int TIMER_W = $clog2(TMAX + 1);

  logic [TIMER_W-1:0] timer;
  logic               nullSeen;
  logic [CRED_W:0]    creditSum;

  // cycles spent in the current state, saturating
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.timerClear) timer <= '0;
    else if (timer != TIMER_W'(TMAX)) timer <= timer + 1'b1;
  end

  // NULL received since the last recovery
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.nullClear) nullSeen <= 1'b0;
    else if (gotNull) nullSeen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.creditClear) txCredit <= '0;
    else begin
      case ({ctrl.creditAdd, ctrl.creditTake})
        2'b10:   txCredit <= txCredit + CRED_W'(CREDIT_STEP);
        2'b01:   txCredit <= txCredit - 1'b1;
        2'b11:   txCredit <= txCredit + CRED_W'(CREDIT_STEP - 1);
        default: txCredit <= txCredit;
      endcase
    end
  end

  always_comb begin
    creditSum                = {1'b0, txCredit} + (CRED_W + 1)'(CREDIT_STEP);
    stat.resetDone           = (timer == TIMER_W'(RESET_CYC - 1));
    stat.timeoutHit          = (timer == TIMER_W'(TIMEOUT_CYC - 1));
    stat.nullSeen            = nullSeen;
    stat.creditWouldOverflow = (creditSum > (CRED_W + 1)'(CREDIT_MAX));
    stat.creditAvail         = (txCredit != '0);
  end
endmodule

// File: rtl/spwLinkControl.sv
`timescale 1ns/1ps
module spwLinkControl
  import spwLinkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoStart,
  input  logic       linkStart,
  input  logic       linkDis,
  input  logic       gotNull,
  input  logic       gotFct,
  input  logic       gotData,
  input  logic       rxDisconnect,
  input  logic       rxParityErr,
  input  logic       rxEscapeErr,
  input  logic       txCharSent,
  input  dpStat_t    stat,
  output dpCtrl_t    ctrl,
  output linkState_t state,
  output logic       errDisc,
  output logic       errPar,
  output logic       errEsc,
  output logic       errCred
);
  linkState_t nextState;
  logic rxFault, nullKnown, fctBad, creditLive, inRun;

  always_comb begin
    rxFault    = rxDisconnect | rxParityErr | rxEscapeErr;
    nullKnown  = gotNull | stat.nullSeen;
    creditLive = (state == ST_CONNECTING) || (state == ST_RUN);
    inRun      = (state == ST_RUN);
    fctBad     = gotFct & stat.creditWouldOverflow & creditLive;
    nextState  = state;
    case (state)
      ST_ERR_RESET:
        if (stat.resetDone) nextState = ST_ERR_WAIT;
      ST_ERR_WAIT:
        if (rxFault || gotFct || gotData) nextState = ST_ERR_RESET;
        else if (stat.timeoutHit)         nextState = ST_READY;
      ST_READY:
        if (rxFault || gotFct || gotData) nextState = ST_ERR_RESET;
        else if (!linkDis && (linkStart || (autoStart && nullKnown)))
          nextState = ST_STARTED;
      ST_STARTED:
        if (linkDis || rxFault || gotFct || gotData || stat.timeoutHit)
          nextState = ST_ERR_RESET;
        else if (nullKnown) nextState = ST_CONNECTING;
      ST_CONNECTING:
        if (linkDis || rxFault || gotData || fctBad || stat.timeoutHit)
          nextState = ST_ERR_RESET;
        else if (gotFct) nextState = ST_RUN;
      ST_RUN:
        if (linkDis || rxFault || fctBad) nextState = ST_ERR_RESET;
      default: nextState = ST_ERR_RESET;
    endcase

    ctrl.timerClear  = (nextState != state);
    ctrl.nullClear   = (state == ST_ERR_RESET);
    ctrl.creditClear = (nextState != ST_CONNECTING) && (nextState != ST_RUN);
    ctrl.creditAdd   = gotFct && creditLive && !ctrl.creditClear;
    ctrl.creditTake  = txCharSent && inRun && stat.creditAvail && !ctrl.creditClear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_ERR_RESET;
      errDisc <= 1'b0;
      errPar  <= 1'b0;
      errEsc  <= 1'b0;
      errCred <= 1'b0;
    end else begin
      state   <= nextState;
      errDisc <= inRun && rxDisconnect;
      errPar  <= inRun && rxParityErr;
      errEsc  <= inRun && rxEscapeErr;
      errCred <= fctBad;
    end
  end
endmodule

// File: rtl/spwLinkController.sv
`timescale 1ns/1ps
module spwLinkController
  import spwLinkPkg::*;
#(
  parameter int RESET_CYC   = 640,
  parameter int TIMEOUT_CYC = 1280,
  parameter int CREDIT_STEP = 8,
  parameter int CREDIT_MAX  = 56,
  localparam int CRED_W     = $clog2(CREDIT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              autoStart,
  input  logic              linkStart,
  input  logic              linkDis,
  input  logic              gotNull,
  input  logic              gotFct,
  input  logic              gotData,
  input  logic              rxDisconnect,
  input  logic              rxParityErr,
  input  logic              rxEscapeErr,
  input  logic              txCharSent,
  output logic              rxEnable,
  output logic              sendNullOk,
  output logic              sendFctOk,
  output logic              sendDataOk,
  output logic              isStarted,
  output logic              isConnecting,
  output logic              isRunning,
  output logic              errDisc,
  output logic              errPar,
  output logic              errEsc,
  output logic              errCred,
  output logic [CRED_W-1:0] txCredit
);
  dpCtrl_t    dpCtrl;
  dpStat_t    dpStat;
  linkState_t linkState;

  spwLinkControl u_ctrl (
    .clk(clk), .rstN(rstN), .autoStart(autoStart), .linkStart(linkStart),
    .linkDis(linkDis), .gotNull(gotNull), .gotFct(gotFct), .gotData(gotData),
    .rxDisconnect(rxDisconnect), .rxParityErr(rxParityErr),
    .rxEscapeErr(rxEscapeErr), .txCharSent(txCharSent), .stat(dpStat),
    .ctrl(dpCtrl), .state(linkState), .errDisc(errDisc), .errPar(errPar),
    .errEsc(errEsc), .errCred(errCred)
  );

  spwLinkDatapath #(
    .RESET_CYC(RESET_CYC), .TIMEOUT_CYC(TIMEOUT_CYC),
    .CREDIT_STEP(CREDIT_STEP), .CREDIT_MAX(CREDIT_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl), .gotNull(gotNull),
    .stat(dpStat), .txCredit(txCredit)
  );

  always_comb begin
    isStarted    = (linkState == ST_STARTED);
    isConnecting = (linkState == ST_CONNECTING);
    isRunning    = (linkState == ST_RUN);
    rxEnable     = (linkState != ST_ERR_RESET);
    sendNullOk   = isStarted | isConnecting | isRunning;
    sendFctOk    = isConnecting | isRunning;
    sendDataOk   = isRunning;
  end
endmodule

// File: rtl/spwLinkChecker.sv
`timescale 1ns/1ps
module spwLinkChecker #(
  parameter int CREDIT_MAX  = 56,
  localparam int CRED_W     = $clog2(CREDIT_MAX + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              linkDis,
  input logic              rxEnable,
  input logic              sendDataOk,
  input logic              isStarted,
  input logic              isConnecting,
  input logic              isRunning,
  input logic              errDisc,
  input logic              errPar,
  input logic              errEsc,
  input logic              errCred,
  input logic [CRED_W-1:0] txCredit
);
  // R4
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isStarted) |-> !$past(linkDis));
  // R4
  dis_teardown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRunning && linkDis) |=> (!isRunning && !rxEnable));
  // R5
  run_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isRunning) |-> $past(isConnecting));
  // R5
  conn_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isConnecting) |-> $past(isStarted));
  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errDisc || errPar || errEsc) |=> !(errDisc || errPar || errEsc));
  // R8
  err_recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errDisc || errPar || errEsc || errCred) |-> !rxEnable);
  // R9
  cred_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCred |=> !errCred);
  // R9
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    txCredit <= CRED_W'(CREDIT_MAX));
  // R11
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isStarted, isConnecting, isRunning}));
  // R10
  data_perm_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendDataOk |-> rxEnable);
endmodule

bind spwLinkController spwLinkChecker #(.CREDIT_MAX(CREDIT_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .linkDis(linkDis), .rxEnable(rxEnable),
  .sendDataOk(sendDataOk), .isStarted(isStarted), .isConnecting(isConnecting),
  .isRunning(isRunning), .errDisc(errDisc), .errPar(errPar), .errEsc(errEsc),
  .errCred(errCred), .txCredit(txCredit)
);

// File: tb/spwLinkController_tb.sv
`timescale 1ns/1ps
module spwLinkController_tb;
  localparam int RST_C  = 8;
  localparam int TMO_C  = 16;
  localparam int STEP_C = 8;
  localparam int MAX_C  = 56;
  localparam int CW     = $clog2(MAX_C + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoStart = 0, linkStart = 0, linkDis = 0;
  logic gotNull = 0, gotFct = 0, gotData = 0;
  logic rxDisconnect = 0, rxParityErr = 0, rxEscapeErr = 0, txCharSent = 0;
  logic rxEnable, sendNullOk, sendFctOk, sendDataOk;
  logic isStarted, isConnecting, isRunning;
  logic errDisc, errPar, errEsc, errCred;
  logic [CW-1:0] txCredit;

  int vecs = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spwLinkController #(
    .RESET_CYC(RST_C), .TIMEOUT_CYC(TMO_C), .CREDIT_STEP(STEP_C), .CREDIT_MAX(MAX_C)
  ) u_dut (
    .clk(clk), .rstN(rstN), .autoStart(autoStart), .linkStart(linkStart),
    .linkDis(linkDis), .gotNull(gotNull), .gotFct(gotFct), .gotData(gotData),
    .rxDisconnect(rxDisconnect), .rxParityErr(rxParityErr),
    .rxEscapeErr(rxEscapeErr), .txCharSent(txCharSent), .rxEnable(rxEnable),
    .sendNullOk(sendNullOk), .sendFctOk(sendFctOk), .sendDataOk(sendDataOk),
    .isStarted(isStarted), .isConnecting(isConnecting), .isRunning(isRunning),
    .errDisc(errDisc), .errPar(errPar), .errEsc(errEsc), .errCred(errCred),
    .txCredit(txCredit)
  );

  // status code: started*8 + connecting*4 + running*2 + rxEnable
  function automatic int statusCode();
    return {28'd0, isStarted, isConnecting, isRunning, rxEnable};
  endfunction
  function automatic int errCode();
    return {28'd0, errDisc, errPar, errEsc, errCred};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic resetDut();
    rstN = 0; autoStart = 0; linkStart = 0; linkDis = 0;
    gotNull = 0; gotFct = 0; gotData = 0; txCharSent = 0;
    rxDisconnect = 0; rxParityErr = 0; rxEscapeErr = 0;
    repeat (3) step();
    rstN = 1;
  endtask

  task automatic goReady();
    resetDut();
    repeat (RST_C + TMO_C) step();
  endtask
  task automatic goStarted();
    goReady();
    linkStart = 1; step(); linkStart = 0;
  endtask
  task automatic goConnecting();
    goStarted();
    gotNull = 1; step(); gotNull = 0;
  endtask
  task automatic goRun();
    goConnecting();
    gotFct = 1; step(); gotFct = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++;
      vecs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int n;
    #2;
    // R1: reset state
    resetDut();
    chk("R1 reset status", statusCode(), 0);
    n = 0;
    while (!rxEnable && n < 200) begin step(); n++; end
    chk("R1 recovery length", n, RST_C);
    // R2: settling then start
    linkStart = 1;
    n = 0;
    while (!isStarted && n < 200) begin step(); n++; end
    chk("R2 settle+start edges", n, TMO_C + 1);
    linkStart = 0;
    // R10 in Started
    chk("R10 perms started", {sendNullOk, sendFctOk, sendDataOk}, 3'b100);
    chk("R11 started status", statusCode(), 9);

    // R3: idle stays idle
    goReady();
    repeat (40) step();
    chk("R3 idle holds", statusCode(), 1);
    autoStart = 1;
    repeat (5) step();
    chk("R3 autostart waits for NULL", statusCode(), 1);
    gotNull = 1; step(); gotNull = 0;
    chk("R3 autostart on NULL", statusCode(), 9);
    step();
    chk("R5 sticky NULL to connecting", statusCode(), 5);
    autoStart = 0;

    // R4: disable priority
    goReady();
    linkStart = 1; linkDis = 1; autoStart = 1;
    repeat (5) step();
    gotNull = 1; step(); gotNull = 0;
    chk("R4 dis blocks start", statusCode(), 1);
    linkDis = 0; step();
    chk("R4 start after dis released", isStarted, 1);
    linkStart = 0; autoStart = 0;
    goRun();
    linkDis = 1; step(); linkDis = 0;
    chk("R4 dis tears down run", statusCode(), 0);
    chk("R4 no error on dis", errCode(), 0);

    // R5 / R10 handshake
    goConnecting();
    chk("R5 connecting", statusCode(), 5);
    chk("R10 perms connecting", {sendNullOk, sendFctOk, sendDataOk}, 3'b110);
    gotFct = 1; step(); gotFct = 0;
    chk("R5 run on FCT", statusCode(), 3);
    chk("R5 first credit", txCredit, STEP_C);
    chk("R10 perms run", {sendNullOk, sendFctOk, sendDataOk}, 3'b111);

    // R6: timeouts
    goStarted();
    n = 0;
    while (isStarted && n < 200) begin step(); n++; end
    chk("R6 started timeout", n, TMO_C);
    chk("R6 started to recovery", rxEnable, 0);
    goConnecting();
    n = 0;
    while (isConnecting && n < 200) begin step(); n++; end
    chk("R6 connecting timeout", n, TMO_C);
    chk("R6 connecting to recovery", rxEnable, 0);

    // R7: unexpected characters
    goStarted();
    gotData = 1; step(); gotData = 0;
    chk("R7 data in started", statusCode() * 16 + errCode(), 0);
    goStarted();
    gotFct = 1; step(); gotFct = 0;
    chk("R7 FCT in started", statusCode() * 16 + errCode(), 0);
    goConnecting();
    gotData = 1; step(); gotData = 0;
    chk("R7 data in connecting", statusCode() * 16 + errCode(), 0);

    // R8: run errors, each pulse one cycle
    for (int e = 0; e < 3; e++) begin
      goRun();
      rxDisconnect = (e == 0); rxParityErr = (e == 1); rxEscapeErr = (e == 2);
      step();
      rxDisconnect = 0; rxParityErr = 0; rxEscapeErr = 0;
      chk("R8 error pulse", errCode(), 8 >> e);
      chk("R8 back to recovery", statusCode(), 0);
      step();
      chk("R8 pulse cleared", errCode(), 0);
    end

    // R9: credit sweep
    goRun();
    for (int k = 1; k <= (MAX_C - STEP_C) / STEP_C; k++) begin
      gotFct = 1; step(); gotFct = 0;
      chk("R9 credit add", txCredit, STEP_C + k * STEP_C);
    end
    for (int k = 1; k <= 5; k++) begin
      txCharSent = 1; step(); txCharSent = 0;
      chk("R9 credit take", txCredit, MAX_C - k);
    end
    gotFct = 1; step(); gotFct = 0;
    chk("R9 overflow pulse", errCode(), 1);
    chk("R9 overflow recovery", statusCode(), 0);
    step();
    chk("R9 overflow cleared", errCode(), 0);
    goRun();
    txCharSent = 1;
    repeat (STEP_C + 3) step();
    txCharSent = 0;
    chk("R9 credit floor", txCredit, 0);
    chk("R9 still running at zero", isRunning, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule